// File: doc/BRIEF.md
# I2C Slave Transfer Sequencer

This block is the control state machine that sits behind an I2C slave protocol front end and decides whether an addressed transfer may proceed. Software arms each direction ahead of time with a single-cycle prepare pulse. When the front end reports an address match, the sequencer grants the transfer only if the requested direction is armed. Entering the transfer consumes that arming, so each prepare allows exactly one transfer.

The sequencer reports its progress with single-cycle event pulses: transmit-started, receive-started and stopped. It drives a grant level that the data path uses to acknowledge and move bytes. A repeated start returns the machine to its decision point, so the new direction is checked against the arming again. A stop condition or a stop task ends the transfer. The slave address is captured when the block is enabled and is held while the block runs.

Top module: `i2cs_xfer_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, state_o is 0 (disabled), grant_o is low and no event pulses. The state encoding is 0 disabled, 1 idle, 2 transmit, 3 receive.
- R2: With enable_i high in the disabled state, the next clock moves state_o to 1. On that same edge own_addr_o takes the value of own_addr_i.
- R3: In idle, an address match with addr_read_i=1 (read) and transmit armed moves to state 2 on the next clock, with one pulse on tx_started_o. grant_o is high while in state 2 or 3.
- R4: In idle, an address match with addr_read_i=0 (write) and receive armed moves to state 3 on the next clock, with one pulse on rx_started_o.
- R5: An address match for a direction that is not armed leaves the state at 1, keeps grant_o low, pulses no event and leaves both armings unchanged.
- R6: Entering state 2 clears the transmit arming and entering state 3 clears the receive arming. A second match in the same direction without a new prepare is refused.
- R7: restart_i in state 2 or 3 returns to state 1 with no event. The next address match is then checked against the armings again.
- R8: stop_cond_i in state 2 or 3 returns to state 1 and pulses stopped_o once. A stop condition takes priority over a restart in the same cycle.
- R9: While enabled, stop_task_i clears both armings, returns to state 1 and pulses stopped_o once.
- R10: enable_i low forces state 0 on the next clock and clears both armings, and no event pulses.
- R11: A prepare pulse in the same cycle as a matching address match is applied first, so the transfer is entered.
- R12: Changes on own_addr_i while the block is enabled do not alter own_addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable level |
| own_addr_i | input | AW | Slave address, captured when the block is enabled |
| prep_tx_i | input | 1 | Prepare-transmit task pulse |
| prep_rx_i | input | 1 | Prepare-receive task pulse |
| stop_task_i | input | 1 | Stop task pulse |
| addr_match_i | input | 1 | Front end: own address matched |
| addr_read_i | input | 1 | Direction of the match, 1 = read |
| restart_i | input | 1 | Front end: repeated start seen |
| stop_cond_i | input | 1 | Front end: stop condition seen |
| tx_started_o | output | 1 | Transmit-started event pulse |
| rx_started_o | output | 1 | Receive-started event pulse |
| stopped_o | output | 1 | Stopped event pulse |
| state_o | output | 2 | Current state (0 disabled, 1 idle, 2 tx, 3 rx) |
| grant_o | output | 1 | Data path may acknowledge and transfer |
| own_addr_o | output | AW | Captured slave address |

## Verification
The assertions check several rules on every cycle: at most one event pulses at a time, each started event coincides with entry from idle, a low enable leads to the disabled state with no events, a stop task leads to idle with a stopped pulse, and the captured address stays fixed while the block runs. The arming flags are hidden, so only the bench scenarios can show them. These scenarios cover consumption by a transfer, survival across a refused match, clearing by stop or disable, and the same-cycle prepare-and-match case. Each one is observed through later address matches that are either granted or refused.

// File: rtl/i2cs_seq_pkg.sv
package i2cs_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_IDLE = 2'd1,
    ST_TX   = 2'd2,
    ST_RX   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/i2cs_arm_flags.sv
module i2cs_arm_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic set_tx_i,
  input  logic set_rx_i,
  input  logic take_tx_i,
  input  logic take_rx_i,
  output logic tx_eff_o,
  output logic rx_eff_o
);
  logic tx_q, rx_q;

  // prepare in the current cycle counts before any front-end decision
  assign tx_eff_o = !clear_i && (tx_q || set_tx_i);
  assign rx_eff_o = !clear_i && (rx_q || set_rx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= 1'b0;
      rx_q <= 1'b0;
    end else begin
      tx_q <= tx_eff_o && !take_tx_i;
      rx_q <= rx_eff_o && !take_rx_i;
    end
  end
endmodule

// File: rtl/i2cs_addr_hold.sv
module i2cs_addr_hold #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= addr_i;
  end
endmodule

// File: rtl/i2cs_seq_fsm.sv
module i2cs_seq_fsm
  import i2cs_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       stop_task_i,
  input  logic       tx_eff_i,
  input  logic       rx_eff_i,
  input  logic       addr_match_i,
  input  logic       addr_read_i,
  input  logic       restart_i,
  input  logic       stop_cond_i,
  output logic       take_tx_o,
  output logic       take_rx_o,
  output logic       load_cfg_o,
  output logic       tx_started_o,
  output logic       rx_started_o,
  output logic       stopped_o,
  output seq_state_e state_o
);
  seq_state_e state_d;
  logic tx_ev_d, rx_ev_d, stop_ev_d;

  assign load_cfg_o = enable_i && (state_o == ST_OFF);

  always_comb begin
    state_d   = state_o;
    take_tx_o = 1'b0;
    take_rx_o = 1'b0;
    tx_ev_d   = 1'b0;
    rx_ev_d   = 1'b0;
    stop_ev_d = 1'b0;
    if (!enable_i) begin
      state_d = ST_OFF;
    end else if (state_o == ST_OFF) begin
      state_d = ST_IDLE;
    end else if (stop_task_i) begin
      state_d   = ST_IDLE;
      stop_ev_d = 1'b1;
    end else begin
      unique case (state_o)
        ST_IDLE: begin
          if (addr_match_i && addr_read_i && tx_eff_i) begin
            state_d   = ST_TX;
            take_tx_o = 1'b1;
            tx_ev_d   = 1'b1;
          end else if (addr_match_i && !addr_read_i && rx_eff_i) begin
            state_d   = ST_RX;
            take_rx_o = 1'b1;
            rx_ev_d   = 1'b1;
          end
        end
        ST_TX, ST_RX: begin
          if (stop_cond_i) begin
            state_d   = ST_IDLE;
            stop_ev_d = 1'b1;
          end else if (restart_i) begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o      <= ST_OFF;
      tx_started_o <= 1'b0;
      rx_started_o <= 1'b0;
      stopped_o    <= 1'b0;
    end else begin
      state_o      <= state_d;
      tx_started_o <= tx_ev_d;
      rx_started_o <= rx_ev_d;
      stopped_o    <= stop_ev_d;
    end
  end
endmodule

// File: rtl/i2cs_xfer_seq.sv
module i2cs_xfer_seq
  import i2cs_seq_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic [AW-1:0] own_addr_i,
  input  logic          prep_tx_i,
  input  logic          prep_rx_i,
  input  logic          stop_task_i,
  input  logic          addr_match_i,
  input  logic          addr_read_i,
  input  logic          restart_i,
  input  logic          stop_cond_i,
  output logic          tx_started_o,
  output logic          rx_started_o,
  output logic          stopped_o,
  output logic [1:0]    state_o,
  output logic          grant_o,
  output logic [AW-1:0] own_addr_o
);
  logic tx_eff, rx_eff, take_tx, take_rx, load_cfg, flag_clr;
  seq_state_e state_q;

  // disable and the stop task both drop any arming
  assign flag_clr = !enable_i || stop_task_i;

  i2cs_arm_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (flag_clr),
    .set_tx_i  (prep_tx_i),
    .set_rx_i  (prep_rx_i),
    .take_tx_i (take_tx),
    .take_rx_i (take_rx),
    .tx_eff_o  (tx_eff),
    .rx_eff_o  (rx_eff)
  );

  i2cs_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .stop_task_i  (stop_task_i),
    .tx_eff_i     (tx_eff),
    .rx_eff_i     (rx_eff),
    .addr_match_i (addr_match_i),
    .addr_read_i  (addr_read_i),
    .restart_i    (restart_i),
    .stop_cond_i  (stop_cond_i),
    .take_tx_o    (take_tx),
    .take_rx_o    (take_rx),
    .load_cfg_o   (load_cfg),
    .tx_started_o (tx_started_o),
    .rx_started_o (rx_started_o),
    .stopped_o    (stopped_o),
    .state_o      (state_q)
  );

  i2cs_addr_hold #(.AW(AW)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_cfg),
    .addr_i (own_addr_i),
    .addr_o (own_addr_o)
  );

  assign state_o = state_q;
  assign grant_o = (state_q == ST_TX) || (state_q == ST_RX);
endmodule

// File: rtl/i2cs_xfer_seq_chk.sv
module i2cs_xfer_seq_chk
  import i2cs_seq_pkg::*;
#(
  parameter int AW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enable_i,
  input logic          stop_task_i,
  input logic          tx_started_o,
  input logic          rx_started_o,
  input logic          stopped_o,
  input logic [1:0]    state_o,
  input logic          grant_o,
  input logic [AW-1:0] own_addr_o
);
  a_r10_disable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (state_o == ST_OFF) && !tx_started_o && !rx_started_o && !stopped_o);

  a_r3_events_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_started_o, rx_started_o, stopped_o}));

  a_r3_tx_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_started_o |-> (state_o == ST_TX) && ($past(state_o) == ST_IDLE) && grant_o);

  a_r4_rx_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_started_o |-> (state_o == ST_RX) && ($past(state_o) == ST_IDLE) && grant_o);

  a_r9_stop_task: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && stop_task_i && state_o != ST_OFF) |=> (state_o == ST_IDLE) && stopped_o);

  a_r12_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_OFF && $past(state_o) != ST_OFF) |-> $stable(own_addr_o));
endmodule

bind i2cs_xfer_seq i2cs_xfer_seq_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .stop_task_i  (stop_task_i),
  .tx_started_o (tx_started_o),
  .rx_started_o (rx_started_o),
  .stopped_o    (stopped_o),
  .state_o      (state_o),
  .grant_o      (grant_o),
  .own_addr_o   (own_addr_o)
);

// File: tb/i2cs_xfer_seq_tb_top.sv
module i2cs_xfer_seq_tb_top;
  localparam int AW = 7;

  typedef struct {
    logic [1:0]    st;
    logic          tx, rx, sp;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, pt = 0, pr = 0, stk = 0, am = 0, rd = 0, rs = 0, sc = 0;
  logic [AW-1:0] addr_in = '0;
  logic tx_o, rx_o, sp_o, gnt_o;
  logic [1:0] st_o;
  logic [AW-1:0] addr_o;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  i2cs_xfer_seq #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .own_addr_i(addr_in),
    .prep_tx_i(pt), .prep_rx_i(pr), .stop_task_i(stk),
    .addr_match_i(am), .addr_read_i(rd), .restart_i(rs), .stop_cond_i(sc),
    .tx_started_o(tx_o), .rx_started_o(rx_o), .stopped_o(sp_o),
    .state_o(st_o), .grant_o(gnt_o), .own_addr_o(addr_o)
  );

  task automatic cmp(string tag, logic [1:0] s, logic t, logic r, logic p, logic g,
                     logic [AW-1:0] a);
    checks++;
    if (st_o !== s || tx_o !== t || rx_o !== r || sp_o !== p || gnt_o !== g || addr_o !== a) begin
      errors++;
      $display("FAIL %s: got st=%0d tx=%b rx=%b stop=%b gnt=%b addr=%h exp st=%0d tx=%b rx=%b stop=%b gnt=%b addr=%h",
               tag, st_o, tx_o, rx_o, sp_o, gnt_o, addr_o, s, t, r, p, g, a);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the outcome expected after the next edge
  task automatic step(logic e, logic ptx, logic prx, logic stt, logic m, logic r,
                      logic rst, logic stc, logic [AW-1:0] a,
                      logic [1:0] xs, logic xt, logic xr, logic xp, logic [AW-1:0] xa,
                      string tag);
    exp_t it;
    @(negedge clk);
    en = e; pt = ptx; pr = prx; stk = stt; am = m; rd = r; rs = rst; sc = stc; addr_in = a;
    it.st = xs; it.tx = xt; it.rx = xr; it.sp = xp; it.addr = xa; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        cmp(it.tag, it.st, it.tx, it.rx, it.sp, (it.st >= 2'd2), it.addr);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #9;
    cmp("R1 in reset", 2'd0, 0, 0, 0, 0, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    cmp("R1 after reset", 2'd0, 0, 0, 0, 0, '0);
    //   en pt pr st am rd rs sc addr   st tx rx sp addr
    step(1, 0, 0, 0, 0, 0, 0, 0, 7'h2A, 1, 0, 0, 0, 7'h2A, "R2 enable to idle");
    step(1, 0, 0, 0, 0, 0, 0, 0, 7'h55, 1, 0, 0, 0, 7'h2A, "R12 addr held");
    step(1, 0, 0, 0, 1, 1, 0, 0, 7'h55, 1, 0, 0, 0, 7'h2A, "R5 unarmed read");
    step(1, 0, 1, 0, 0, 0, 0, 0, 7'h55, 1, 0, 0, 0, 7'h2A, "R4 prepare rx");
    step(1, 0, 0, 0, 1, 1, 0, 0, 7'h55, 1, 0, 0, 0, 7'h2A, "R5 read refused rx armed");
    step(1, 0, 0, 0, 1, 0, 0, 0, 7'h55, 3, 0, 1, 0, 7'h2A, "R4 write enters rx, R5 arming kept");
    step(1, 0, 0, 0, 0, 0, 0, 0, 7'h55, 3, 0, 0, 0, 7'h2A, "R4 rx held");
    step(1, 0, 0, 0, 0, 0, 1, 1, 7'h55, 1, 0, 0, 1, 7'h2A, "R8 stop cond over restart");
    step(1, 0, 0, 0, 1, 0, 0, 0, 7'h55, 1, 0, 0, 0, 7'h2A, "R6 rx arming consumed");
    step(1, 1, 0, 0, 0, 0, 0, 0, 7'h55, 1, 0, 0, 0, 7'h2A, "R3 prepare tx");
    step(1, 0, 0, 0, 1, 1, 0, 0, 7'h55, 2, 1, 0, 0, 7'h2A, "R3 read enters tx");
    step(1, 0, 1, 0, 1, 0, 0, 0, 7'h55, 2, 0, 0, 0, 7'h2A, "R7 arm rx during tx");
    step(1, 0, 0, 0, 0, 0, 1, 0, 7'h55, 1, 0, 0, 0, 7'h2A, "R7 restart to idle");
    step(1, 0, 0, 0, 1, 0, 0, 0, 7'h55, 3, 0, 1, 0, 7'h2A, "R7 recheck write granted");
    step(1, 0, 0, 0, 0, 0, 1, 0, 7'h55, 1, 0, 0, 0, 7'h2A, "R7 restart from rx");
    step(1, 0, 0, 0, 1, 1, 0, 0, 7'h55, 1, 0, 0, 0, 7'h2A, "R6 tx arming consumed");
    step(1, 1, 1, 0, 0, 0, 0, 0, 7'h55, 1, 0, 0, 0, 7'h2A, "R9 arm both");
    step(1, 0, 0, 1, 0, 0, 0, 0, 7'h55, 1, 0, 0, 1, 7'h2A, "R9 stop task in idle");
    step(1, 0, 0, 0, 1, 1, 0, 0, 7'h55, 1, 0, 0, 0, 7'h2A, "R9 tx cleared");
    step(1, 0, 0, 0, 1, 0, 0, 0, 7'h55, 1, 0, 0, 0, 7'h2A, "R9 rx cleared");
    step(1, 1, 0, 0, 1, 1, 0, 0, 7'h55, 2, 1, 0, 0, 7'h2A, "R11 prepare with match");
    step(1, 0, 0, 1, 0, 0, 0, 0, 7'h55, 1, 0, 0, 1, 7'h2A, "R9 stop task in tx");
    step(1, 0, 1, 0, 0, 0, 0, 0, 7'h55, 1, 0, 0, 0, 7'h2A, "R10 arm rx");
    step(0, 0, 0, 0, 0, 0, 0, 0, 7'h55, 0, 0, 0, 0, 7'h2A, "R10 disable");
    step(1, 0, 0, 0, 0, 0, 0, 0, 7'h55, 1, 0, 0, 0, 7'h55, "R2 re-enable loads addr");
    step(1, 0, 0, 0, 1, 0, 0, 0, 7'h2A, 1, 0, 0, 0, 7'h55, "R10 rx cleared by disable");
    step(1, 0, 1, 0, 1, 0, 0, 0, 7'h2A, 3, 0, 1, 0, 7'h55, "R11 prepare rx with write");
    step(0, 0, 0, 0, 0, 0, 0, 0, 7'h2A, 0, 0, 0, 0, 7'h55, "R10 disable from rx no event");
    step(0, 0, 0, 0, 0, 0, 0, 0, 7'h2A, 0, 0, 0, 0, 7'h55, "R10 stays off");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule